// File: doc/BRIEF.md
# Channel-0 Positive Input Sequencer for a Multi-Input ADC

This block chooses which analog input feeds the positive side of the first sample-and-hold channel for each sample. It has three ways of working. In fixed mode it always uses preset A. In alternating mode it uses preset A for the first sample, preset B for the next one, and keeps swapping on every later sample. In scan mode it steps through the inputs whose bit is set in a mask. The sequencing controller pulses a strobe each time a sample is finished. The block then moves to the selection for the next sample. Its outputs are a 4-bit input number and a flag that shows which preset side is in use.

The block is built around a three-state machine. `ST_OFF` means the module is disabled. `ST_SIDE_A` means the next sample uses preset A, or the scan pointer when scan is on. `ST_SIDE_B` means the next sample uses preset B. The state machine has these transitions:

- enable: `ST_OFF` to `ST_SIDE_A`
- swap: `ST_SIDE_A` to `ST_SIDE_B`, on a sample strobe with alternating mode on
- return: `ST_SIDE_B` to `ST_SIDE_A`, on a sample strobe
- restart: any active state to `ST_SIDE_A`, on the restart strobe
- disable: any state to `ST_OFF`

A scan cursor sits beside the state machine. After each side-A sample in scan mode, the cursor moves past the input that was just used. The input for the next sample is the lowest set mask bit at or above the cursor, wrapping around past the top input. The cursor goes back to zero on restart and on disable. A restart is pulsed at each interrupt boundary.

Top module: `adc_ch0_mux_seq`

## Requirements
- R1: While `enable` is low, which includes during and after reset, `ch_sel` equals `sel_a` and `use_b` is 0.
- R2: With `alt_mode` = 0 and `scan_en` = 0, every sample uses `sel_a` and `use_b` stays 0.
- R3: With `alt_mode` = 1, the first sample after enable or restart is side A (`use_b` = 0). After that, each sample strobe swaps sides.
- R4: On side B, `ch_sel` equals `sel_b` and `use_b` is 1.
- R5: With `scan_en` = 1 and a nonzero mask, the first side-A sample after enable or restart selects the lowest set bit of `scan_mask`. Bit i of the mask stands for input number i.
- R6: In scan mode, each side-A sample strobe moves the selection to the next higher set mask bit. Clear bits are skipped.
- R7: After the highest set mask bit has been used, the scan wraps to the lowest set bit.
- R8: With `scan_en` = 1 and an all-zero mask, side-A samples use `sel_a`.
- R9: With scan and alternating mode both on, side-B samples use `sel_b` and do not move the scan cursor.
- R10: A `seq_restart` pulse returns the block to side A and to the start of the scan. It takes priority over a `sample_done` in the same cycle.
- R11: Disabling the block also clears the side and the scan cursor. On re-enable, selection starts again from side A and the lowest set mask bit.
- R12: Clearing `alt_mode` while on side B makes the output show side A (`sel_a` or the scan pick, `use_b` = 0) in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module on; when low, the sequence is held at its start |
| seq_restart | input | 1 | One-cycle strobe at an interrupt boundary; restarts the sequence |
| sample_done | input | 1 | One-cycle strobe at the end of each sample |
| alt_mode | input | 1 | Alternate between presets A and B |
| scan_en | input | 1 | Scan the masked inputs on side A |
| sel_a | input | 4 | Preset A input number |
| sel_b | input | 4 | Preset B input number |
| scan_mask | input | 16 | Inputs included in the scan, bit i = input i |
| ch_sel | output | 4 | Input number for the next sample |
| use_b | output | 1 | 1 when preset B is in use |

## Verification
Some properties are checked by assertions on every cycle. The scan pick must always be a set bit of the mask whenever scanning is active. The cursor must stay put unless it advances or is cleared. A side B must always be followed by a side A. Restart and disable must always land on side A. Other behaviour can only be shown by the bench's directed scenarios, because it depends on a particular history of strobes. That covers the exact order of the scan, the wrap, how scan and alternation interleave, the restart that collides with a sample strobe, and what happens after re-enable.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SIDE_A = 2'd1,
        ST_SIDE_B = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_scan_pick.sv
module adc_scan_pick #(
    parameter int SEL_W = 4,
    localparam int NUM_IN = 1 << SEL_W
) (
    input  logic [NUM_IN-1:0] mask,
    input  logic [SEL_W-1:0]  cursor,
    output logic [SEL_W-1:0]  pick,
    output logic              any_set
);

    logic [NUM_IN-1:0] rot;
    logic [SEL_W-1:0]  offset;

    // rot[g] is the mask bit g positions above the cursor, modulo NUM_IN
    for (genvar g = 0; g < NUM_IN; g++) begin : g_rot
        logic [SEL_W-1:0] idx;
        assign idx    = cursor + SEL_W'(g);
        assign rot[g] = mask[idx];
    end

    always_comb begin
        offset = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (rot[i]) begin
                offset = SEL_W'(i);
            end
        end
    end

    assign any_set = |mask;
    assign pick    = cursor + offset;

endmodule

// File: rtl/adc_scan_cursor.sv
module adc_scan_cursor #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [SEL_W-1:0] used,
    output logic [SEL_W-1:0] cursor
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cursor <= '0;
        end else if (clear) begin
            cursor <= '0;
        end else if (advance) begin
            cursor <= used + SEL_W'(1);
        end
    end

    // R9: the cursor moves only when advanced or cleared
    p_cursor_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !advance) |=> $stable(cursor));

    // R10 / R11: a clear always returns the cursor to zero
    p_cursor_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cursor == '0));

endmodule

// File: rtl/adc_ab_fsm.sv
module adc_ab_fsm
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       seq_restart,
    input  logic       sample_done,
    input  logic       alt_mode,
    output seq_state_e state,
    output logic       side_b,
    output logic       side_a
);

    seq_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = ST_OFF;
        end else if (seq_restart) begin
            state_nx = ST_SIDE_A;
        end else begin
            unique case (state)
                ST_OFF:    state_nx = ST_SIDE_A;
                ST_SIDE_A: if (sample_done && alt_mode) state_nx = ST_SIDE_B;
                ST_SIDE_B: if (sample_done) state_nx = ST_SIDE_A;
                default:   state_nx = ST_OFF;
            endcase
        end
    end

    // Side B is only shown while alternating is still requested
    always_comb begin
        side_b = 1'b0;
        side_a = 1'b0;
        unique case (state)
            ST_OFF:    ;
            ST_SIDE_A: side_a = 1'b1;
            ST_SIDE_B: begin
                side_b = alt_mode;
                side_a = !alt_mode;
            end
            default:   ;
        endcase
    end

    // R3: a sample taken on side B is always followed by side A
    p_b_then_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !seq_restart && sample_done && state == ST_SIDE_B) |=> (state == ST_SIDE_A));

    // R3: with alternation on, a side-A sample leads to side B
    p_a_then_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !seq_restart && sample_done && alt_mode && state == ST_SIDE_A) |=> (state == ST_SIDE_B));

    // R10: restart lands on side A
    p_restart_side_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && seq_restart) |=> (state == ST_SIDE_A));

endmodule

// File: rtl/adc_ch0_mux_seq.sv
module adc_ch0_mux_seq
    import adc_seq_pkg::*;
#(
    parameter int SEL_W = 4,
    localparam int NUM_IN = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              seq_restart,
    input  logic              sample_done,
    input  logic              alt_mode,
    input  logic              scan_en,
    input  logic [SEL_W-1:0]  sel_a,
    input  logic [SEL_W-1:0]  sel_b,
    input  logic [NUM_IN-1:0] scan_mask,
    output logic [SEL_W-1:0]  ch_sel,
    output logic              use_b
);

    seq_state_e       state;
    logic             side_a;
    logic             side_b;
    logic [SEL_W-1:0] cursor;
    logic [SEL_W-1:0] pick;
    logic             any_set;
    logic             scanning;
    logic             advance;
    logic             clear;

    adc_ab_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .seq_restart (seq_restart),
        .sample_done (sample_done),
        .alt_mode    (alt_mode),
        .state       (state),
        .side_b      (side_b),
        .side_a      (side_a)
    );

    adc_scan_pick #(.SEL_W(SEL_W)) u_pick (
        .mask    (scan_mask),
        .cursor  (cursor),
        .pick    (pick),
        .any_set (any_set)
    );

    assign scanning = side_a && scan_en && any_set;
    assign clear    = !enable || seq_restart;
    assign advance  = enable && !seq_restart && sample_done && scanning;

    adc_scan_cursor #(.SEL_W(SEL_W)) u_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .advance (advance),
        .used    (pick),
        .cursor  (cursor)
    );

    always_comb begin
        ch_sel = sel_a;
        use_b  = 1'b0;
        if (side_b) begin
            ch_sel = sel_b;
            use_b  = 1'b1;
        end else if (scanning) begin
            ch_sel = pick;
        end
    end

    // R1: once disabled, side A's preset is presented
    p_off_preset_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!use_b && ch_sel == sel_a));

    // R6: a scan selection is always an enabled mask input
    p_scan_in_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF && !use_b && scan_en && |scan_mask) |-> scan_mask[ch_sel]);

    // R8: an empty mask falls back to preset A
    p_empty_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF && !use_b && scan_en && scan_mask == '0) |-> (ch_sel == sel_a));

    // R12: side B is never shown with alternation off
    p_no_b_without_alt_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_mode |-> !use_b);

endmodule

// File: tb/tb_adc_ch0_mux_seq.sv
module tb_adc_ch0_mux_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        seq_restart;
    logic        sample_done;
    logic        alt_mode;
    logic        scan_en;
    logic [3:0]  sel_a;
    logic [3:0]  sel_b;
    logic [15:0] scan_mask;
    logic [3:0]  ch_sel;
    logic        use_b;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_ch0_mux_seq dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .seq_restart (seq_restart),
        .sample_done (sample_done),
        .alt_mode    (alt_mode),
        .scan_en     (scan_en),
        .sel_a       (sel_a),
        .sel_b       (sel_b),
        .scan_mask   (scan_mask),
        .ch_sel      (ch_sel),
        .use_b       (use_b)
    );

    task automatic check(input string req, input logic [3:0] exp_ch, input logic exp_b);
        #1;
        checks++;
        if (ch_sel !== exp_ch || use_b !== exp_b) begin
            errors++;
            $display("FAIL %s: ch_sel=%0d use_b=%0b, expected ch_sel=%0d use_b=%0b",
                     req, ch_sel, use_b, exp_ch, exp_b);
        end
    endtask

    task automatic step();
        sample_done = 1'b1;
        @(negedge clk);
        sample_done = 1'b0;
    endtask

    task automatic restart();
        seq_restart = 1'b1;
        @(negedge clk);
        seq_restart = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 in reset", 4'd5, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        step();
        check("R1 disabled after reset", 4'd5, 1'b0);
    endtask

    task automatic t_fixed();
        enable = 1'b1;
        @(negedge clk);
        check("R2 first sample", 4'd5, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step();
            check("R2 fixed", 4'd5, 1'b0);
        end
    endtask

    task automatic t_alternate();
        alt_mode = 1'b1;
        restart();
        check("R3 starts on A", 4'd5, 1'b0);
        step();
        check("R4 side B", 4'd9, 1'b1);
        step();
        check("R3 back to A", 4'd5, 1'b0);
        step();
        check("R4 side B again", 4'd9, 1'b1);
        alt_mode = 1'b0;
        check("R12 alt cleared on B", 4'd5, 1'b0);
        step();
        check("R12 stays A", 4'd5, 1'b0);
    endtask

    task automatic t_scan();
        scan_mask = 16'h8412;
        scan_en   = 1'b1;
        restart();
        check("R5 lowest set bit", 4'd1, 1'b0);
        step();
        check("R6 next set bit", 4'd4, 1'b0);
        step();
        check("R6 skip clear bits", 4'd10, 1'b0);
        step();
        check("R6 top bit", 4'd15, 1'b0);
        step();
        check("R7 wrap", 4'd1, 1'b0);
        step();
        check("R7 after wrap", 4'd4, 1'b0);
    endtask

    task automatic t_empty();
        scan_mask = 16'h0000;
        check("R8 empty mask", 4'd5, 1'b0);
        step();
        check("R8 empty mask after sample", 4'd5, 1'b0);
    endtask

    task automatic t_scan_alt();
        scan_mask = 16'h0084;
        alt_mode  = 1'b1;
        restart();
        check("R9 scan A first", 4'd2, 1'b0);
        step();
        check("R9 B preset", 4'd9, 1'b1);
        step();
        check("R9 scan next A", 4'd7, 1'b0);
        step();
        check("R9 B preset again", 4'd9, 1'b1);
        step();
        check("R9 scan wraps", 4'd2, 1'b0);
        step();
        check("R9 B preset third", 4'd9, 1'b1);
    endtask

    task automatic t_collide();
        seq_restart = 1'b1;
        sample_done = 1'b1;
        @(negedge clk);
        seq_restart = 1'b0;
        sample_done = 1'b0;
        check("R10 restart beats sample", 4'd2, 1'b0);
        step();
        check("R10 B after restart", 4'd9, 1'b1);
        step();
        check("R10 scan continues", 4'd7, 1'b0);
    endtask

    task automatic t_disable();
        enable = 1'b0;
        @(negedge clk);
        check("R1 disabled output", 4'd5, 1'b0);
        step();
        check("R11 sample ignored while off", 4'd5, 1'b0);
        enable = 1'b1;
        @(negedge clk);
        check("R11 re-enable from start", 4'd2, 1'b0);
    endtask

    initial begin
        rst_n       = 1'b0;
        enable      = 1'b0;
        seq_restart = 1'b0;
        sample_done = 1'b0;
        alt_mode    = 1'b0;
        scan_en     = 1'b0;
        sel_a       = 4'd5;
        sel_b       = 4'd9;
        scan_mask   = 16'h0000;
        @(negedge clk);
        t_reset();
        t_fixed();
        t_alternate();
        t_scan();
        t_empty();
        t_scan_alt();
        t_collide();
        t_disable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule